// File: doc/BRIEF.md
# Keyed Watchdog Timer

A countdown watchdog on a simple word-addressed register bus. Software sets a reload value and a control word. While counting is on, the counter decrements once per selected tick and then waits at zero. It is reloaded only when software writes a 16-bit key to the restart register. When the counter steps from one to zero, a sticky zero flag is set and a pulse of programmable length starts. The pulse appears on up to three outputs: a system reset request, an interrupt, and an external signal. Each output has its own enable bit.

The count tick is either every bus clock or a single-cycle tick enable that is synchronous to the bus clock, such as a 5 MHz strobe made elsewhere. The zero flag is cleared through its own write-only register. Generating the tick and acting on the reset request are left to the surrounding logic.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter and the load register both read 0x03EF1480, the pulse-length register reads 0x000000FF, and control, status and all three outputs are 0.
- R2: A write to byte offset 0x08 (restart) whose bits 15:0 equal 0x5AB9 loads the counter from the load register at offset 0x04; bits 31:16 of that write are ignored.
- R3: A restart write whose bits 15:0 differ from 0x5AB9 leaves the counter unchanged.
- R4: While control bit 0 is 1, the counter, read at offset 0x00, drops by one on each selected tick. It stays at zero until a valid restart, and it holds its value while control bit 0 is 0.
- R5: Control bit 4 selects the tick. When it is 0 every clock is a tick; when it is 1 only the clocks with tick_in high are ticks.
- R6: Status bit 0 (offset 0x10) becomes 1 when a tick takes the counter from 1 to 0, and it stays 1 until a write with bit 0 set to offset 0x14. A clear write with bit 0 at 0 has no effect, and if the set and the clear fall in the same cycle the set wins.
- R7: The pulse is active during the N+1 cycles that follow the clock edge at which the counter becomes zero, where N is the 8-bit value at offset 0x18.
- R8: Each output shows the pulse only when its own enable is set: control bit 1 for rst_req_o, bit 2 for irq_o, and bit 3 for ext_o.
- R9: Reserved bits read as zero. Control keeps only bits 4:0 and the pulse-length register only bits 7:0. The write-only offsets 0x08 and 0x14, and unused offsets, read as zero.
- R10: A valid restart takes priority over a tick in the same cycle, and writing the load register does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; read data is valid in the same cycle |
| addr | input | 5 | Byte address; bits 1:0 are ignored |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data; zero when rd_en is low |
| tick_in | input | 1 | Single-cycle tick enable, synchronous to clk |
| rst_req_o | output | 1 | Gated pulse: system reset request |
| irq_o | output | 1 | Gated pulse: interrupt |
| ext_o | output | 1 | Gated pulse: external signal |

## Verification
The assertions check on every cycle the rules that hold from one cycle to the next:
- the counter holds at zero;
- in bus-clock mode it steps down by exactly one, and in tick mode it stays put on idle ticks;
- it reloads after a valid key;
- the zero flag stays set until a clear;
- no pulse starts without the zero flag.

Only the bench scenarios can show the longer-range effects:
- the exact pulse length and the cycle in which the pulse starts, swept over several load and length values;
- the gating by each output enable;
- which restart keys are rejected;
- the set-over-clear and restart-over-tick collisions;
- the values that reserved bits and write-only registers read back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Word index (byte address bits 4:2) of each register
  typedef enum logic [2:0] {
    REG_COUNT   = 3'd0,
    REG_LOAD    = 3'd1,
    REG_RESTART = 3'd2,
    REG_CTRL    = 3'd3,
    REG_STATUS  = 3'd4,
    REG_CLEAR   = 3'd5,
    REG_PULSE   = 3'd6
  } wdtReg_e;

  localparam int CTRL_W       = 5;
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_RST_EN  = 1;
  localparam int CTRL_IRQ_EN  = 2;
  localparam int CTRL_EXT_EN  = 3;
  localparam int CTRL_TICKSEL = 4;

  // Strobes sent from the control block to the datapath
  typedef struct packed {
    logic restart;
    logic clearZero;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W = 32,
  parameter int LEN_W = 8,
  parameter int KEY_W = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'h03EF1480,
  parameter logic [LEN_W-1:0] LEN_RST = 8'hFF,
  parameter logic [KEY_W-1:0] KEY = 16'h5AB9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              zeroFlag,
  output logic [DATA_W-1:0] rdData,
  output wdtStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadVal,
  output logic [LEN_W-1:0]  lenVal,
  output logic [CTRL_W-1:0] ctrlBits
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  logic keyMatch;
  assign keyMatch = (wrData[KEY_W-1:0] == KEY);

  always_comb begin
    strobe = '0;
    strobe.restart   = wrEn && (idx == IDX_W'(REG_RESTART)) && keyMatch;
    strobe.clearZero = wrEn && (idx == IDX_W'(REG_CLEAR)) && wrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal  <= LOAD_RST;
      lenVal   <= LEN_RST;
      ctrlBits <= '0;
    end else if (wrEn) begin
      if (idx == IDX_W'(REG_LOAD))  loadVal  <= wrData[CNT_W-1:0];
      if (idx == IDX_W'(REG_PULSE)) lenVal   <= wrData[LEN_W-1:0];
      if (idx == IDX_W'(REG_CTRL))  ctrlBits <= wrData[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (idx)
        IDX_W'(REG_COUNT):  rdData = DATA_W'(cntVal);
        IDX_W'(REG_LOAD):   rdData = DATA_W'(loadVal);
        IDX_W'(REG_CTRL):   rdData = DATA_W'(ctrlBits);
        IDX_W'(REG_STATUS): rdData = DATA_W'(zeroFlag);
        IDX_W'(REG_PULSE):  rdData = DATA_W'(lenVal);
        default:            rdData = '0;
      endcase
    end
  end

  // R9: the unused control bits read back as zero
  a_r9_ctrl_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx == IDX_W'(REG_CTRL)) |-> (rdData[DATA_W-1:CTRL_W] == '0));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 8,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'h03EF1480
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [LEN_W-1:0] lenVal,
  input  logic             countEn,
  input  logic             tickSel,
  input  logic             tickIn,
  output logic [CNT_W-1:0] cntVal,
  output logic             zeroFlag,
  output logic             pulseActive
);
  localparam int PULSE_W = LEN_W + 1;

  logic tickNow, zeroHit;
  logic [PULSE_W-1:0] pulseRem;

  assign tickNow = countEn && (tickSel ? tickIn : 1'b1);
  assign zeroHit = tickNow && (cntVal == CNT_W'(1)) && !strobe.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= LOAD_RST;
    end else if (strobe.restart) begin
      cntVal <= loadVal;
    end else if (tickNow && cntVal != '0) begin
      cntVal <= cntVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 zeroFlag <= 1'b0;
    else if (zeroHit)          zeroFlag <= 1'b1;
    else if (strobe.clearZero) zeroFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseRem <= '0;
    else if (zeroHit)        pulseRem <= PULSE_W'(lenVal) + PULSE_W'(1);
    else if (pulseRem != '0) pulseRem <= pulseRem - PULSE_W'(1);
  end

  assign pulseActive = (pulseRem != '0);

  a_r2_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cntVal == $past(loadVal)));
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == '0 && !strobe.restart) |=> (cntVal == '0));
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !tickSel && cntVal != '0 && !strobe.restart) |=>
      (cntVal == $past(cntVal) - CNT_W'(1)));
  a_r5_idle_tick: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && tickSel && !tickIn && !strobe.restart) |=> $stable(cntVal));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (zeroFlag && !strobe.clearZero) |=> zeroFlag);
  a_r7_pulse_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> zeroFlag);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W = 32,
  parameter int LEN_W = 8,
  parameter int KEY_W = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'h03EF1480,
  parameter logic [LEN_W-1:0] LEN_RST = 8'hFF,
  parameter logic [KEY_W-1:0] KEY = 16'h5AB9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_in,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              ext_o
);
  wdtStrobe_t        strobe;
  logic [CNT_W-1:0]  loadVal, cntVal;
  logic [LEN_W-1:0]  lenVal;
  logic [CTRL_W-1:0] ctrlBits;
  logic              zeroFlag, pulseActive;

  wdt_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
    .KEY_W(KEY_W), .LOAD_RST(LOAD_RST), .LEN_RST(LEN_RST), .KEY(KEY)
  ) uCtrl (
    .clk(clk), .rstN(rst_n), .wrEn(wr_en), .rdEn(rd_en), .addr(addr),
    .wrData(wr_data), .cntVal(cntVal), .zeroFlag(zeroFlag), .rdData(rd_data),
    .strobe(strobe), .loadVal(loadVal), .lenVal(lenVal), .ctrlBits(ctrlBits)
  );

  wdt_core #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .LOAD_RST(LOAD_RST)
  ) uCore (
    .clk(clk), .rstN(rst_n), .strobe(strobe), .loadVal(loadVal),
    .lenVal(lenVal), .countEn(ctrlBits[CTRL_RUN]),
    .tickSel(ctrlBits[CTRL_TICKSEL]), .tickIn(tick_in), .cntVal(cntVal),
    .zeroFlag(zeroFlag), .pulseActive(pulseActive)
  );

  assign rst_req_o = pulseActive && ctrlBits[CTRL_RST_EN];
  assign irq_o     = pulseActive && ctrlBits[CTRL_IRQ_EN];
  assign ext_o     = pulseActive && ctrlBits[CTRL_EXT_EN];

  // R8: no output pulses unless its enable bit is set
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o || irq_o || ext_o) |-> (ctrlBits[3:1] != 3'b000));
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, tick_in = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic rst_req_o, irq_o, ext_o;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wdt_keyed u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tick_in(tick_in),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .ext_o(ext_o)
  );

  localparam logic [4:0] A_CNT = 5'h00, A_LOAD = 5'h04, A_RESTART = 5'h08,
    A_CTRL = 5'h0C, A_STAT = 5'h10, A_CLR = 5'h14, A_LEN = 5'h18, A_NONE = 5'h1C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1;
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_in = 1'b1;
    @(negedge clk);
    tick_in = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CNT, d);  chk("R1 counter", d, 32'h03EF1480);
    rd(A_LOAD, d); chk("R1 load", d, 32'h03EF1480);
    rd(A_LEN, d);  chk("R1 len", d, 32'h000000FF);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 outputs", {29'b0, rst_req_o, irq_o, ext_o}, 0);

    // R9 reserved and write-only reads
    wr(A_CTRL, 32'hFFFF_FFE0);
    rd(A_CTRL, d); chk("R9 ctrl reserved", d, 0);
    wr(A_LEN, 32'hFFFF_FF03);
    rd(A_LEN, d); chk("R9 len width", d, 32'h03);
    rd(A_RESTART, d); chk("R9 restart reads 0", d, 0);
    rd(A_CLR, d); chk("R9 clear reads 0", d, 0);
    rd(A_NONE, d); chk("R9 unused reads 0", d, 0);

    // R4 disabled counter holds
    wr(A_LOAD, 32'd10);
    wr(A_RESTART, 32'h0000_5AB9);
    rd(A_CNT, d); chk("R2 reload", d, 10);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R4 hold when disabled", d, 10);

    // R3 wrong keys
    wr(A_LOAD, 32'd20);
    rd(A_CNT, d); chk("R10 load write keeps counter", d, 10);
    wr(A_RESTART, 32'h0000_5AB8);
    rd(A_CNT, d); chk("R3 wrong key low", d, 10);
    wr(A_RESTART, 32'h5AB9_0000);
    rd(A_CNT, d); chk("R3 key in upper half", d, 10);
    wr(A_RESTART, 32'hFFFF_5AB9);
    rd(A_CNT, d); chk("R2 upper bits ignored", d, 20);

    // R5 tick-select mode
    wr(A_CTRL, 32'h11);
    repeat (4) @(negedge clk);
    rd(A_CNT, d); chk("R5 no tick no count", d, 20);
    for (int k = 1; k <= 6; k++) begin
      tick();
      @(negedge clk);
      rd(A_CNT, d); chk("R5 per tick", d, 32'(20 - k));
    end

    // R4 stop at zero
    wr(A_LOAD, 32'd2);
    wr(A_RESTART, 32'h5AB9);
    repeat (5) tick();
    rd(A_CNT, d); chk("R4 stops at zero", d, 0);
    rd(A_STAT, d); chk("R6 status set", d, 1);
    wr(A_CLR, 32'h2);
    rd(A_STAT, d); chk("R6 clear bit0=0 ignored", d, 1);
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); chk("R6 cleared", d, 0);

    // R6 set wins over clear in the same cycle
    wr(A_LOAD, 32'd1);
    wr(A_RESTART, 32'h5AB9);
    @(negedge clk);
    tick_in = 1'b1; wr_en = 1'b1; addr = A_CLR; wr_data = 32'h1;
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd(A_STAT, d); chk("R6 set wins", d, 1);
    rd(A_CNT, d); chk("R4 reached zero", d, 0);

    // R10 restart wins over tick
    wr(A_LOAD, 32'd5);
    wr(A_RESTART, 32'h5AB9);
    tick(); tick();
    rd(A_CNT, d); chk("R5 two ticks", d, 3);
    @(negedge clk);
    tick_in = 1'b1; wr_en = 1'b1; addr = A_RESTART; wr_data = 32'h5AB9;
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0; wr_data = '0;
    rd(A_CNT, d); chk("R10 restart beats tick", d, 5);

    // R7/R8 sweep in bus-clock mode
    for (int ld = 1; ld <= 4; ld++) begin
      for (int ln = 0; ln <= 3; ln++) begin
        logic [2:0] m;
        m = 3'((ld * 4 + ln) % 8);
        wr(A_CTRL, {27'b0, 1'b0, m, 1'b1});
        wr(A_LEN, 32'(ln));
        wr(A_CLR, 32'h1);
        wr(A_LOAD, 32'(ld));
        wr(A_RESTART, 32'h5AB9);
        for (int j = 0; j <= ld + ln + 2; j++) begin
          logic act;
          act = (j >= ld) && (j <= ld + ln);
          chk($sformatf("R7 R8 ld=%0d len=%0d j=%0d", ld, ln, j),
              {29'b0, ext_o, irq_o, rst_req_o},
              {29'b0, act & m[2], act & m[1], act & m[0]});
          @(negedge clk);
        end
        rd(A_STAT, d); chk("R6 status after sweep", d, 1);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule